// File: doc/BRIEF.md
# Single to Double Pixel Converter

This block takes a stream of one 24-bit pixel per clock, together with its data-enable, horizontal sync and vertical sync, and repacks it for a dual-channel panel interface. In double-wide mode it gathers two successive pixels into a pair and presents them together on port A (the earlier pixel) and port B (the later pixel). A one-clock strobe marks each new pair, so a pair appears on every second clock. In single-wide mode every pixel is passed straight to port A and no pairing takes place.

Pairing is driven by a divide-by-2 phase. The phase can be pulled back to the A slot by a chosen event: the data-enable rising edge, the hsync rising edge or the vsync rising edge. It can also be left free-running. With the data-enable source the first active pixel of every line lands on port A, whatever the parity of the active or blanking counts. This is the source to use when the sync pulses sit after the active region of the line. Pixels outside the active region are presented as zero, so a line with an odd pixel count ends in a pair whose B half is zero. Each port then has its own inversion control, and the sync and enable outputs are registered together with the data they belong to.

Top module: `pixel_pair_conv`

## Requirements
- R1: While reset is high, and on the clock after it is released, pix_a, pix_b, de_out, hs_out, vs_out and pair_vld are all zero.
- R2: In double-wide mode (wide_mode=1) the converter alternates between an A-slot clock and a B-slot clock. On each B-slot clock, after that clock edge, pix_a shows the pixel from the preceding A-slot clock and pix_b shows the current pixel, and pair_vld is high for exactly that one cycle. The outputs hold their values between pairs.
- R3: With sync_sel=0, a rising edge of de_in places that pixel in the A slot. If this edge arrives on what would have been a B-slot clock, the pending half-pair is dropped and no pair is presented on that edge.
- R4: With sync_sel=1, a rising edge of hs_in makes that clock an A-slot clock, and a rising edge of de_in has no effect on the phase.
- R5: With sync_sel=2, a rising edge of vs_in makes that clock an A-slot clock, and a rising edge of hs_in has no effect on the phase.
- R6: With sync_sel=3, the phase is never realigned. The first clock after reset is an A slot, and the slots alternate from then on.
- R7: A pixel sampled with de_in low is presented as zero. A line that ends on an A-slot pixel therefore produces a pair whose B half is zero, with de_out high.
- R8: When inv_a is high, every bit of pix_a is inverted; when inv_b is high, every bit of pix_b is inverted. Inversion is applied after the zeroing of R7.
- R9: In double-wide mode, hs_out and vs_out carry the sync values that were sampled with the A-slot pixel of the pair. de_out is high if either pixel of the pair was sampled with de_in high.
- R10: In single-wide mode (wide_mode=0), after every clock edge pix_a shows the pixel of that clock, with R7 and R8 applied. pix_b is zero before inversion, de_out, hs_out and vs_out follow their inputs one clock later, and pair_vld is high. Pixels are carried unchanged as {red[23:16], green[15:8], blue[7:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 = double-wide pairing, 0 = single-wide pass |
| sync_sel | input | 2 | Phase realign source: 0 data-enable rise, 1 hsync rise, 2 vsync rise, 3 free-running |
| inv_a | input | 1 | Invert all bits of port A |
| inv_b | input | 1 | Invert all bits of port B |
| de_in | input | 1 | Data enable of the incoming pixel |
| hs_in | input | 1 | Horizontal sync of the incoming pixel |
| vs_in | input | 1 | Vertical sync of the incoming pixel |
| pix_in | input | 24 | Incoming pixel {red, green, blue} |
| pix_a | output | 24 | Port A pixel (earlier pixel of the pair) |
| pix_b | output | 24 | Port B pixel (later pixel of the pair) |
| de_out | output | 1 | Data enable aligned to the output pair |
| hs_out | output | 1 | Horizontal sync aligned to the output pair |
| vs_out | output | 1 | Vertical sync aligned to the output pair |
| pair_vld | output | 1 | High for one cycle when a new pair is presented |

## Verification
Two things can land on the same clock: a realign event and the completion of a pair. The case that matters is a data-enable rising edge that arrives exactly when the phase would have closed a pair. The bench forces this by leaving a single blanking pixel after reset before the first active pixel. It then checks that pair_vld stays low on that edge and that the next pair holds the first and second active pixels on A and B. For contrast, the free-running and hsync-sourced scenarios put an active pixel on a B slot on purpose, and the bench checks that port A is zero there while port B carries the pixel.

// File: rtl/pxpair_pkg.sv
package pxpair_pkg;

    localparam int CH_W  = 8;
    localparam int PIX_W = 3 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pixel_t;

    typedef enum logic [1:0] {
        SYNC_DE   = 2'd0,
        SYNC_HS   = 2'd1,
        SYNC_VS   = 2'd2,
        SYNC_FREE = 2'd3
    } resync_src_e;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } ctl_t;

    typedef struct packed {
        pixel_t pix;
        ctl_t   ctl;
    } beat_t;

    typedef struct packed {
        pixel_t a;
        pixel_t b;
        ctl_t   ctl;
        logic   vld;
    } pair_t;

    // Pixels outside the active region travel as zero.
    function automatic pixel_t blank_gate(pixel_t p, logic de);
        return de ? p : pixel_t'('0);
    endfunction

    function automatic pixel_t apply_inv(pixel_t p, logic inv);
        return p ^ pixel_t'({PIX_W{inv}});
    endfunction

endpackage

// File: rtl/pp_phase_gen.sv
module pp_phase_gen
    import pxpair_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wide,
    input  resync_src_e sel,
    input  ctl_t        ctl_in,
    output logic        resync,
    output logic        cur_ph
);
    ctl_t prev_q;
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            ph_q   <= 1'b0;
        end else begin
            prev_q <= ctl_in;
            ph_q   <= wide ? ~cur_ph : 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SYNC_DE: resync = ctl_in.de & ~prev_q.de;
            SYNC_HS: resync = ctl_in.hs & ~prev_q.hs;
            SYNC_VS: resync = ctl_in.vs & ~prev_q.vs;
            default: resync = 1'b0;
        endcase
        cur_ph = (resync || !wide) ? 1'b0 : ph_q;
    end

    // R6: without realign, double-wide phase must alternate every clock
    assert_phase_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (wide && !resync) ##1 (wide && !resync) |-> (cur_ph != $past(cur_ph)));

endmodule

// File: rtl/pp_pair_pack.sv
module pp_pair_pack
    import pxpair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wide,
    input  logic  cur_ph,
    input  beat_t beat,
    output pair_t nxt
);
    beat_t hold_q;
    pixel_t cur_pix;

    assign cur_pix = blank_gate(beat.pix, beat.ctl.de);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wide && !cur_ph) begin
            hold_q.pix <= cur_pix;
            hold_q.ctl <= beat.ctl;
        end
    end

    always_comb begin
        nxt = '0;
        if (!wide) begin
            nxt.a   = cur_pix;
            nxt.b   = '0;
            nxt.ctl = beat.ctl;
            nxt.vld = 1'b1;
        end else if (cur_ph) begin
            nxt.a      = hold_q.pix;
            nxt.b      = cur_pix;
            nxt.ctl.hs = hold_q.ctl.hs;
            nxt.ctl.vs = hold_q.ctl.vs;
            nxt.ctl.de = hold_q.ctl.de | beat.ctl.de;
            nxt.vld    = 1'b1;
        end
    end

endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage
    import pxpair_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wide,
    input  logic   inv_a,
    input  logic   inv_b,
    input  pair_t  nxt,
    output pixel_t port_q [2],
    output ctl_t   ctl_q,
    output logic   vld_q
);
    localparam int N_PORT = 2;

    logic   inv_v [N_PORT];
    pixel_t src_v [N_PORT];

    assign inv_v[0] = inv_a;
    assign inv_v[1] = inv_b;
    assign src_v[0] = nxt.a;
    assign src_v[1] = nxt.b;

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                port_q[p] <= '0;
            end else if (nxt.vld) begin
                port_q[p] <= apply_inv(src_v[p], inv_v[p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            vld_q <= 1'b0;
        end else begin
            if (nxt.vld) begin
                ctl_q <= nxt.ctl;
            end
            vld_q <= nxt.vld;
        end
    end

    // R2: in double-wide mode a pair strobe is never followed by another
    assert_vld_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (vld_q && wide) ##1 wide |-> !vld_q);

    // R10: single-wide mode presents a pixel after every edge
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !wide |=> vld_q);

endmodule

// File: rtl/pixel_pair_conv.sv
module pixel_pair_conv
    import pxpair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_mode,
    input  logic [1:0]       sync_sel,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_a,
    output logic [PIX_W-1:0] pix_b,
    output logic             de_out,
    output logic             hs_out,
    output logic             vs_out,
    output logic             pair_vld
);
    beat_t  beat;
    logic   resync;
    logic   cur_ph;
    pair_t  nxt;
    pixel_t port_q [2];
    ctl_t   ctl_q;

    assign beat.pix    = pixel_t'(pix_in);
    assign beat.ctl.de = de_in;
    assign beat.ctl.hs = hs_in;
    assign beat.ctl.vs = vs_in;

    pp_phase_gen u_phase (
        .clk    (clk),
        .rst    (rst),
        .wide   (wide_mode),
        .sel    (resync_src_e'(sync_sel)),
        .ctl_in (beat.ctl),
        .resync (resync),
        .cur_ph (cur_ph)
    );

    pp_pair_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .wide   (wide_mode),
        .cur_ph (cur_ph),
        .beat   (beat),
        .nxt    (nxt)
    );

    pp_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .wide   (wide_mode),
        .inv_a  (inv_a),
        .inv_b  (inv_b),
        .nxt    (nxt),
        .port_q (port_q),
        .ctl_q  (ctl_q),
        .vld_q  (pair_vld)
    );

    assign pix_a  = port_q[0];
    assign pix_b  = port_q[1];
    assign de_out = ctl_q.de;
    assign hs_out = ctl_q.hs;
    assign vs_out = ctl_q.vs;

    // R3: a realign edge starts a pair, so no pair is closed on it
    assert_resync_no_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && resync) |=> !pair_vld);

    // R7: a blank B-slot pixel shows as zero (then inverted per R8)
    assert_blank_b_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && cur_ph && !de_in) |=> (pix_b == {PIX_W{$past(inv_b)}}));

endmodule

// File: tb/test_pixel_pair_conv.sv
module test_pixel_pair_conv;
    localparam int CLK_P = 10;
    localparam int PW    = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wide_mode = 1'b1;
    logic [1:0]    sync_sel = 2'd0;
    logic          inv_a = 1'b0;
    logic          inv_b = 1'b0;
    logic          de_in = 1'b0;
    logic          hs_in = 1'b0;
    logic          vs_in = 1'b0;
    logic [PW-1:0] pix_in = '0;
    logic [PW-1:0] pix_a, pix_b;
    logic          de_out, hs_out, vs_out, pair_vld;

    int total = 0;
    int bad   = 0;

    localparam logic [PW-1:0] P0 = 24'hA1B2C3;
    localparam logic [PW-1:0] P1 = 24'h14253F;
    localparam logic [PW-1:0] P2 = 24'h7E0D99;
    localparam logic [PW-1:0] P3 = 24'h5A5A01;
    localparam logic [PW-1:0] P4 = 24'hC0FFEE;

    always #(CLK_P/2) clk = ~clk;

    pixel_pair_conv i_pixel_pair_conv (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .sync_sel(sync_sel),
        .inv_a(inv_a), .inv_b(inv_b), .de_in(de_in), .hs_in(hs_in),
        .vs_in(vs_in), .pix_in(pix_in), .pix_a(pix_a), .pix_b(pix_b),
        .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out), .pair_vld(pair_vld)
    );

    task automatic chk(input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic chk_pair(input string tag, input logic [PW-1:0] ea, input logic [PW-1:0] eb,
                            input logic ede, input logic evld);
        chk({tag, " pix_a"}, pix_a, ea);
        chk({tag, " pix_b"}, pix_b, eb);
        chk({tag, " de_out"}, PW'(de_out), PW'(ede));
        chk({tag, " pair_vld"}, PW'(pair_vld), PW'(evld));
    endtask

    task automatic do_reset(input logic wide, input logic [1:0] sel);
        rst = 1'b1; wide_mode = wide; sync_sel = sel;
        inv_a = 1'b0; inv_b = 1'b0;
        de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0; pix_in = '0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // One pixel clock: drive, take the edge, sample just after it.
    task automatic step(input logic de, input logic hs, input logic vs, input logic [PW-1:0] p);
        de_in = de; hs_in = hs; vs_in = vs; pix_in = p;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        rst = 1'b1; wide_mode = 1'b1; sync_sel = 2'd0;
        de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1; pix_in = P0;
        @(posedge clk); @(posedge clk); #1;
        chk_pair("R1 in reset", '0, '0, 1'b0, 1'b0);
        chk("R1 hs_out", PW'(hs_out), '0);
        chk("R1 vs_out", PW'(vs_out), '0);
    endtask

    task automatic t_de_line;
        do_reset(1'b1, 2'd0);
        step(0, 0, 0, P3);
        step(0, 0, 0, P3);
        step(1, 0, 0, P0);
        step(1, 0, 0, P1);
        chk_pair("R2 R3 first pair", P0, P1, 1'b1, 1'b1);
        step(1, 0, 0, P2);
        chk_pair("R2 hold between pairs", P0, P1, 1'b1, 1'b0);
        step(1, 0, 0, P3);
        chk_pair("R2 second pair", P2, P3, 1'b1, 1'b1);
        step(1, 0, 0, P4);
        step(0, 0, 0, P1);
        chk_pair("R7 odd line end", P4, '0, 1'b1, 1'b1);
    endtask

    task automatic t_collision;
        do_reset(1'b1, 2'd0);
        step(0, 0, 0, P4);
        step(1, 0, 0, P0);
        chk("R3 no pair on realign edge", PW'(pair_vld), '0);
        step(1, 0, 0, P1);
        chk_pair("R3 first pixel on A after collision", P0, P1, 1'b1, 1'b1);
    endtask

    task automatic t_free;
        do_reset(1'b1, 2'd3);
        step(0, 0, 0, P3);
        step(1, 0, 0, P0);
        chk_pair("R6 free-run first pixel on B", '0, P0, 1'b1, 1'b1);
        step(1, 0, 0, P1);
        step(1, 0, 0, P2);
        chk_pair("R6 free-run next pair", P1, P2, 1'b1, 1'b1);
    endtask

    task automatic t_hs;
        do_reset(1'b1, 2'd1);
        step(0, 0, 0, P3);
        step(0, 1, 0, P3);
        step(0, 1, 0, P3);
        chk("R4 R9 hs_out with pair", PW'(hs_out), PW'(1));
        chk_pair("R4 blank pair after hs", '0, '0, 1'b0, 1'b1);
        step(0, 0, 0, P3);
        step(0, 0, 0, P3);
        chk("R9 hs_out cleared", PW'(hs_out), '0);
        step(1, 0, 0, P0);
        step(1, 0, 0, P1);
        chk_pair("R4 pair aligned by hs", P0, P1, 1'b1, 1'b1);
        step(0, 0, 0, P3);
        step(1, 0, 0, P2);
        chk_pair("R4 de rise ignored", '0, P2, 1'b1, 1'b1);
    endtask

    task automatic t_vs;
        do_reset(1'b1, 2'd2);
        step(0, 0, 0, P3);
        step(0, 0, 1, P3);
        step(0, 0, 1, P3);
        chk("R5 R9 vs_out with pair", PW'(vs_out), PW'(1));
        step(0, 0, 0, P3);
        step(0, 1, 0, P3);
        chk("R5 hs rise ignored, pair closes", PW'(pair_vld), PW'(1));
        step(1, 0, 0, P0);
        step(1, 0, 0, P1);
        chk_pair("R5 pair aligned by vs", P0, P1, 1'b1, 1'b1);
    endtask

    task automatic t_inv;
        do_reset(1'b1, 2'd0);
        inv_a = 1'b1; inv_b = 1'b0;
        step(1, 0, 0, P0);
        step(1, 0, 0, P1);
        chk_pair("R8 invert A only", ~P0, P1, 1'b1, 1'b1);
        inv_a = 1'b0; inv_b = 1'b1;
        step(1, 0, 0, P2);
        step(0, 0, 0, P3);
        chk_pair("R8 R7 invert blank B", P2, '1, 1'b1, 1'b1);
    endtask

    task automatic t_single;
        do_reset(1'b0, 2'd0);
        step(1, 1, 0, P0);
        chk_pair("R10 single pixel", P0, '0, 1'b1, 1'b1);
        chk("R10 hs follows", PW'(hs_out), PW'(1));
        step(0, 0, 1, P4);
        chk_pair("R10 single blank", '0, '0, 1'b0, 1'b1);
        chk("R10 vs follows", PW'(vs_out), PW'(1));
        step(1, 0, 0, P1);
        chk_pair("R10 single next", P1, '0, 1'b1, 1'b1);
    endtask

    initial begin
        #(CLK_P * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_de_line();
        t_collision();
        t_free();
        t_hs();
        t_vs();
        t_inv();
        t_single();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule